// File: doc/BRIEF.md
# Set-Associative Tag Store with Victim Buffer

This block keeps line tags for a four-way set-associative cache and adds a small, fully associative victim buffer next to it. A line pushed out of a full set is not dropped: it is parked in the buffer. Each lookup checks the indexed set and, in the same cycle, compares the full line address against every buffer entry. A buffer hit moves the line back into its set and sends that set's least recently used line into the freed buffer slot, all in one operation. A few overloaded sets can therefore act as if they had a fifth way. How many sets gain this at once is bounded by the number of buffer entries.

A lookup is accepted when `req_ready` and `req_valid` are both high. Its response appears on the next cycle: main hit, victim hit or miss. After a miss the block stalls until memory delivers the line on the fill port. The fill installs the line in the least recently used way of its set. If that way held a line, that line enters the buffer at the buffer's ring position. If that slot was already occupied, the older entry leaves the buffer and is reported on the eviction outputs. Line data is out of scope; a line is identified only by its address. The low `IDX_W` bits of the line address select the set.

The controller has two states. In `ST_IDLE` it accepts lookups. `ST_IDLE -> ST_WAIT_FILL` happens on an accepted miss. In `ST_WAIT_FILL` it ignores lookups. `ST_WAIT_FILL -> ST_IDLE` happens on `fill_valid`. Each state otherwise holds.

Top module: `vbc_top`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `evict_valid` is 0, and every line looks up as a miss.
- R2: A lookup is accepted on a rising edge with `req_ready` and `req_valid` high. In the next cycle `resp_valid` is 1 for one cycle with `resp_code`. The codes are 1 for main hit, 2 for victim hit and 3 for miss (0 is never reported). A line resident in its set gives code 1 and becomes most recently used there.
- R3: The main cache is 4-way. When a line must enter a set, it goes to an empty way if there is one, or else it replaces the least recently used way of the set.
- R4: A lookup that misses its set but matches a buffer entry gives code 2. The line then occupies the set's least recently used way as most recently used. The line previously held in that way takes over the matched buffer entry, or the entry becomes empty if that way was empty.
- R5: A miss (code 3) drops `req_ready` in the cycle the response is shown. It stays low until a fill is taken, and lookups presented meanwhile get no response.
- R6: `fill_valid` while waiting installs the missed line as most recently used in its set, and `req_ready` is 1 in the next cycle. A valid line displaced by the fill is written into the buffer.
- R7: The buffer replaces its slots in ring order. When a fill writes into an occupied slot, `evict_valid` is 1 for one cycle in the next cycle, with `evict_addr` holding the departing address. `evict_valid` is 0 at all other times.
- R8: `fill_valid` while no miss is pending has no effect on either structure and raises no eviction.
- R9: No line is ever held in both the main cache and the buffer at the same time.
- R10: Five lines that share one set, accessed in a repeating cycle, give victim hits on every access once the first round has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Line address of the lookup; low IDX_W bits are the set |
| req_ready | output | 1 | High when a lookup can be accepted |
| resp_valid | output | 1 | Response strobe, one cycle after acceptance |
| resp_code | output | 2 | 1 main hit, 2 victim hit, 3 miss |
| fill_valid | input | 1 | Line for the pending miss has arrived from memory |
| evict_valid | output | 1 | A buffer entry has been pushed out |
| evict_addr | output | ADDR_W | Line address of the pushed-out entry |

## Verification
The bound checker checks the following on every cycle: that no address is found in both structures, that response codes are legal, that the stall follows a miss with no response while it lasts, that the block is ready again after a fill, and that eviction strobes occur only right after a fill. The checker cannot see which way or slot is chosen, so LRU choice, the swap on a buffer hit, ring-order eviction, the five-line cyclic pattern and ignored idle fills are shown only through the bench's directed and random access sequences. Those sequences are compared against a recency-list model.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
    typedef enum logic [1:0] {
        RSP_NONE     = 2'd0,
        RSP_MAIN_HIT = 2'd1,
        RSP_VICT_HIT = 2'd2,
        RSP_MISS     = 2'd3
    } rsp_e;

    typedef enum logic {
        ST_IDLE      = 1'b0,
        ST_WAIT_FILL = 1'b1
    } st_e;
endpackage

// File: rtl/vbc_tag_store.sv
module vbc_tag_store #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 2,
    parameter int WAYS   = 4,
    localparam int SETS  = 1 << IDX_W,
    localparam int TAG_W = ADDR_W - IDX_W,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              upd_en,
    input  logic [WAY_W-1:0]  upd_way,
    input  logic              wr_en,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [WAY_W-1:0]  lru_way,
    output logic              lru_valid,
    output logic [ADDR_W-1:0] lru_addr
);
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic             valid_q [SETS][WAYS];
    logic [WAY_W-1:0] age_q   [SETS][WAYS];

    logic [IDX_W-1:0] set_i;
    logic [TAG_W-1:0] tag_i;
    logic [WAYS-1:0]  hit_vec;

    assign set_i = lk_addr[IDX_W-1:0];
    assign tag_i = lk_addr[ADDR_W-1:IDX_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        lru_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
            if (age_q[set_i][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
        end
    end

    assign lru_valid = valid_q[set_i][lru_way];
    assign lru_addr  = {tag_q[set_i][lru_way], set_i};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w]   <= '0;
                    valid_q[s][w] <= 1'b0;
                    age_q[s][w]   <= WAY_W'(w);
                end
            end
        end else if (upd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == upd_way) begin
                    age_q[set_i][w] <= '0;
                end else if (age_q[set_i][w] < age_q[set_i][upd_way]) begin
                    age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
                end
            end
            if (wr_en) begin
                tag_q[set_i][upd_way]   <= tag_i;
                valid_q[set_i][upd_way] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/vbc_victim_buf.sv
module vbc_victim_buf #(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] srch_addr,
    output logic              hit,
    output logic [PTR_W-1:0]  hit_idx,
    input  logic              swap_en,
    input  logic              swap_valid,
    input  logic [ADDR_W-1:0] swap_addr,
    input  logic              push_en,
    input  logic [ADDR_W-1:0] push_addr,
    output logic              head_valid,
    output logic [ADDR_W-1:0] head_addr
);
    logic [ADDR_W-1:0] addr_q  [DEPTH];
    logic              valid_q [DEPTH];
    logic [PTR_W-1:0]  wp_q;
    logic [DEPTH-1:0]  match;

    for (genvar e = 0; e < DEPTH; e++) begin : g_cam
        assign match[e] = valid_q[e] && (addr_q[e] == srch_addr);
    end

    assign hit = |match;

    always_comb begin
        hit_idx = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (match[e]) hit_idx = PTR_W'(e);
        end
    end

    assign head_valid = valid_q[wp_q];
    assign head_addr  = addr_q[wp_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                addr_q[e]  <= '0;
                valid_q[e] <= 1'b0;
            end
            wp_q <= '0;
        end else begin
            if (swap_en) begin
                addr_q[hit_idx]  <= swap_addr;
                valid_q[hit_idx] <= swap_valid;
            end
            if (push_en) begin
                addr_q[wp_q]  <= push_addr;
                valid_q[wp_q] <= 1'b1;
                wp_q          <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vbc_ctrl.sv
module vbc_ctrl
    import vbc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WAYS   = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              fill_valid,
    input  logic              main_hit,
    input  logic [WAY_W-1:0]  main_hit_way,
    input  logic [WAY_W-1:0]  lru_way,
    input  logic              lru_valid,
    input  logic [ADDR_W-1:0] lru_addr,
    input  logic              vb_hit,
    input  logic              vb_head_valid,
    input  logic [ADDR_W-1:0] vb_head_addr,
    output logic              waiting,
    output logic [ADDR_W-1:0] pend_addr,
    output logic              ts_upd_en,
    output logic [WAY_W-1:0]  ts_upd_way,
    output logic              ts_wr_en,
    output logic              vb_swap_en,
    output logic              vb_push_en,
    output logic              resp_valid,
    output logic [1:0]        resp_code,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_addr
);
    st_e  st_q, st_d;
    rsp_e code_d;
    logic accept, do_fill;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            pend_addr   <= '0;
            resp_valid  <= 1'b0;
            resp_code   <= RSP_NONE;
            evict_valid <= 1'b0;
            evict_addr  <= '0;
        end else begin
            st_q        <= st_d;
            resp_valid  <= accept;
            resp_code   <= accept ? code_d : RSP_NONE;
            evict_valid <= vb_push_en && vb_head_valid;
            if (vb_push_en && vb_head_valid) evict_addr <= vb_head_addr;
            if (accept) pend_addr <= req_addr;
        end
    end

    always_comb begin
        st_d       = st_q;
        accept     = 1'b0;
        do_fill    = 1'b0;
        code_d     = RSP_NONE;
        ts_upd_en  = 1'b0;
        ts_upd_way = lru_way;
        ts_wr_en   = 1'b0;
        vb_swap_en = 1'b0;
        vb_push_en = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                accept = req_valid;
                if (req_valid) begin
                    if (main_hit) begin
                        code_d     = RSP_MAIN_HIT;
                        ts_upd_en  = 1'b1;
                        ts_upd_way = main_hit_way;
                    end else if (vb_hit) begin
                        code_d     = RSP_VICT_HIT;
                        ts_upd_en  = 1'b1;
                        ts_wr_en   = 1'b1;
                        vb_swap_en = 1'b1;
                    end else begin
                        code_d = RSP_MISS;
                        st_d   = ST_WAIT_FILL;
                    end
                end
            end
            ST_WAIT_FILL: begin
                do_fill = fill_valid;
                if (fill_valid) begin
                    ts_upd_en  = 1'b1;
                    ts_wr_en   = 1'b1;
                    vb_push_en = lru_valid;
                    st_d       = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign waiting = (st_q == ST_WAIT_FILL);
endmodule

// File: rtl/vbc_top.sv
module vbc_top #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 2,
    parameter int WAYS   = 4,
    parameter int DEPTH  = 4,
    localparam int WAY_W = $clog2(WAYS),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [1:0]        resp_code,
    input  logic              fill_valid,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_addr
);
    logic              waiting;
    logic [ADDR_W-1:0] pend_addr, look_addr;
    logic              main_hit, lru_valid, vb_hit, vb_head_valid;
    logic [WAY_W-1:0]  main_hit_way, lru_way, ts_upd_way;
    logic [ADDR_W-1:0] lru_addr, vb_head_addr;
    logic [PTR_W-1:0]  vb_hit_idx;
    logic              ts_upd_en, ts_wr_en, vb_swap_en, vb_push_en;
    logic              both_hit;

    assign look_addr = waiting ? pend_addr : req_addr;
    assign req_ready = !waiting;
    assign both_hit  = main_hit && vb_hit;

    vbc_tag_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WAYS(WAYS)) u_ts (
        .clk(clk), .rst_n(rst_n), .lk_addr(look_addr),
        .upd_en(ts_upd_en), .upd_way(ts_upd_way), .wr_en(ts_wr_en),
        .hit(main_hit), .hit_way(main_hit_way), .lru_way(lru_way),
        .lru_valid(lru_valid), .lru_addr(lru_addr)
    );

    vbc_victim_buf #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_vb (
        .clk(clk), .rst_n(rst_n), .srch_addr(look_addr),
        .hit(vb_hit), .hit_idx(vb_hit_idx),
        .swap_en(vb_swap_en), .swap_valid(lru_valid), .swap_addr(lru_addr),
        .push_en(vb_push_en), .push_addr(lru_addr),
        .head_valid(vb_head_valid), .head_addr(vb_head_addr)
    );

    vbc_ctrl #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .fill_valid(fill_valid), .main_hit(main_hit), .main_hit_way(main_hit_way),
        .lru_way(lru_way), .lru_valid(lru_valid), .lru_addr(lru_addr),
        .vb_hit(vb_hit), .vb_head_valid(vb_head_valid), .vb_head_addr(vb_head_addr),
        .waiting(waiting), .pend_addr(pend_addr),
        .ts_upd_en(ts_upd_en), .ts_upd_way(ts_upd_way), .ts_wr_en(ts_wr_en),
        .vb_swap_en(vb_swap_en), .vb_push_en(vb_push_en),
        .resp_valid(resp_valid), .resp_code(resp_code),
        .evict_valid(evict_valid), .evict_addr(evict_addr)
    );
endmodule

// File: rtl/vbc_chk.sv
module vbc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       resp_valid,
    input logic [1:0] resp_code,
    input logic       fill_valid,
    input logic       evict_valid,
    input logic       both_hit
);
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_code != 2'd0)); // R2
    AST_NO_DUAL_RESIDENCE: assert property (@(posedge clk) disable iff (!rst_n)
        !both_hit); // R9
    AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'd3) |-> !req_ready); // R5
    AST_SILENT_WHILE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> !resp_valid); // R5
    AST_READY_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && fill_valid) |=> req_ready); // R6
    AST_EVICT_ONLY_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> ($past(fill_valid) && !$past(req_ready))); // R7
endmodule

bind vbc_top vbc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_code(resp_code), .fill_valid(fill_valid), .evict_valid(evict_valid),
    .both_hit(both_hit)
);

// File: tb/sim_vbc_top.sv
`timescale 1ns/1ps
module sim_vbc_top;
    localparam int AW = 12;
    localparam int IX = 2;
    localparam int NS = 1 << IX;
    localparam int NW = 4;
    localparam int ND = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, fill_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_ready, resp_valid, evict_valid;
    logic [1:0] resp_code;
    logic [AW-1:0] evict_addr;

    int checks = 0, errors = 0, evicts_seen = 0;

    logic [AW-1:0] lst [NS][NW];
    int            cnt [NS];
    logic [AW-1:0] vbq [ND];
    bit            vbv [ND];
    int            wp;

    always #4 clk = ~clk;

    vbc_top #(.ADDR_W(AW), .IDX_W(IX), .WAYS(NW), .DEPTH(ND)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_code(resp_code),
        .fill_valid(fill_valid), .evict_valid(evict_valid), .evict_addr(evict_addr)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic string code_req(input int c);
        if (c == 1) return "R2 main hit";
        if (c == 2) return "R4 victim hit";
        return "R5 miss";
    endfunction

    task automatic put_front(input int s, input logic [AW-1:0] a);
        for (int i = cnt[s] - 1; i > 0; i--) lst[s][i] = lst[s][i-1];
        lst[s][0] = a;
    endtask

    task automatic model_access(input logic [AW-1:0] a, output int code);
        int s, p, v;
        s = int'(a[IX-1:0]); p = -1; v = -1;
        for (int i = 0; i < cnt[s]; i++) if (lst[s][i] == a) p = i;
        for (int e = 0; e < ND; e++) if (vbv[e] && vbq[e] == a) v = e;
        if (p >= 0) begin
            code = 1;
            for (int i = p; i > 0; i--) lst[s][i] = lst[s][i-1];
            lst[s][0] = a;
        end else if (v >= 0) begin
            code = 2;
            if (cnt[s] == NW) vbq[v] = lst[s][NW-1];
            else begin vbv[v] = 1'b0; cnt[s]++; end
            put_front(s, a);
        end else code = 3;
    endtask

    task automatic model_fill(input logic [AW-1:0] a, output bit ev, output logic [AW-1:0] ea);
        int s;
        s = int'(a[IX-1:0]); ev = 1'b0; ea = '0;
        if (cnt[s] == NW) begin
            if (vbv[wp]) begin ev = 1'b1; ea = vbq[wp]; end
            vbq[wp] = lst[s][NW-1];
            vbv[wp] = 1'b1;
            wp = (wp + 1) % ND;
        end else cnt[s]++;
        put_front(s, a);
    endtask

    task automatic access(input logic [AW-1:0] a, output int code);
        bit ev; logic [AW-1:0] ea;
        model_access(a, code);
        @(negedge clk); req_valid = 1'b1; req_addr = a;
        @(negedge clk); req_valid = 1'b0;
        check(resp_valid === 1'b1, "R2 response strobe", int'(resp_valid), 1);
        check(int'(resp_code) == code, code_req(code), int'(resp_code), code);
        check(evict_valid === 1'b0, "R7 no eviction on lookup", int'(evict_valid), 0);
        if (code == 3) begin
            check(req_ready === 1'b0, "R5 stall after miss", int'(req_ready), 0);
            @(negedge clk); fill_valid = 1'b1;
            @(negedge clk); fill_valid = 1'b0;
            model_fill(a, ev, ea);
            check(evict_valid === ev, "R7 eviction strobe", int'(evict_valid), int'(ev));
            if (ev) begin
                evicts_seen++;
                check(evict_addr == ea, "R7 eviction address", int'(evict_addr), int'(ea));
            end
            check(req_ready === 1'b1, "R6 ready after fill", int'(req_ready), 1);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int tag, input int set);
        return {AW'(tag) << IX} | AW'(set);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c, okc;
        void'($urandom(32'd1357));
        for (int s = 0; s < NS; s++) cnt[s] = 0;
        for (int e = 0; e < ND; e++) begin vbv[e] = 1'b0; vbq[e] = '0; end
        wp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(resp_valid === 1'b0, "R1 no response after reset", int'(resp_valid), 0);
        check(evict_valid === 1'b0, "R1 no eviction after reset", int'(evict_valid), 0);

        // R1: first touch misses; R5: lookup during wait gets no response
        model_access(mk(0, 1), c);
        @(negedge clk); req_valid = 1'b1; req_addr = mk(0, 1);
        @(negedge clk);
        check(int'(resp_code) == 3, "R1 empty cache misses", int'(resp_code), 3);
        req_addr = mk(5, 1);
        @(negedge clk);
        check(resp_valid === 1'b0, "R5 lookup ignored while waiting", int'(resp_valid), 0);
        check(req_ready === 1'b0, "R5 still stalled", int'(req_ready), 0);
        req_valid = 1'b0; fill_valid = 1'b1;
        @(negedge clk); fill_valid = 1'b0;
        begin bit ev; logic [AW-1:0] ea; model_fill(mk(0, 1), ev, ea); end
        check(req_ready === 1'b1, "R6 ready after fill", int'(req_ready), 1);
        access(mk(0, 1), c);
        check(c == 1, "R6 filled line hits", c, 1);

        // R8: stray fill while idle
        @(negedge clk); fill_valid = 1'b1;
        @(negedge clk); fill_valid = 1'b0;
        check(evict_valid === 1'b0, "R8 idle fill no eviction", int'(evict_valid), 0);
        check(resp_valid === 1'b0, "R8 idle fill no response", int'(resp_valid), 0);
        access(mk(5, 1), c);
        check(c == 3, "R8 idle fill installed nothing", c, 3);

        // R10: five lines cycling through set 2
        okc = 0;
        for (int r = 0; r < 4; r++)
            for (int t = 0; t < 5; t++) begin
                access(mk(t, 2), c);
                if (r >= 1 && c == 2) okc++;
            end
        check(okc == 15, "R10 cyclic five lines hit in buffer", okc, 15);

        // R3: LRU victim choice in set 0
        for (int t = 0; t < 4; t++) access(mk(t, 0), c);
        access(mk(0, 0), c);
        access(mk(9, 0), c);
        access(mk(0, 0), c);
        check(c == 1, "R3 recently used line kept", c, 1);
        access(mk(1, 0), c);
        check(c == 2, "R3 least recent line moved to buffer", c, 2);

        // R7: overflow the buffer through set 3
        for (int t = 0; t < 10; t++) access(mk(t, 3), c);
        check(evicts_seen > 0, "R7 buffer overflow reported", evicts_seen, 1);

        // random mix
        for (int n = 0; n < 600; n++) begin
            access(mk(int'($urandom % 8), int'($urandom % NS)), c);
            if ($urandom % 5 == 0) begin
                @(negedge clk); fill_valid = 1'b1;
                @(negedge clk); fill_valid = 1'b0;
                check(evict_valid === 1'b0, "R8 random idle fill", int'(evict_valid), 0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule